// File: doc/BRIEF.md
# Serial Flash Command Frame Decoder

This block is the serial-port front end of a page-organised flash model that keeps two SRAM buffers beside its main array. While chip select is low it collects a command frame from the serial data line. A frame is an 8-bit opcode followed by a 24-bit address field. When chip select goes high again, an array command that arrived complete produces one decoded command strobe. The strobe carries the command kind, the page number, the starting byte offset in the buffer and which of the two buffers the command uses.

Read opcodes come in two forms, one per clocking variant. The block does not commit them. As soon as their opcode byte has arrived it raises a read-mode flag together with the read kind and the variant, so the data path can start to respond while the frame is still open. An opcode the block does not know raises a sticky error flag. That flag stays set until the next frame begins. The serial pins are oversampled in the system clock domain, so every output is synchronous to `clk`. Read data, array timing and status contents are handled outside this block.

Top module: `sflash_frame_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released with no frame sent, `cmd_valid`, `cmd_kind`, `cmd_buf`, `cmd_page`, `cmd_offset`, `read_mode`, `read_kind`, `read_spi_mode` and `illegal_op` are all 0.
- R2: The block samples `spi_mosi` on rising `spi_sck` edges while `spi_cs_n` is low, MSB first. Frame bits 31..24 are the opcode, bits 23..19 are reserved, bits 18..9 are the page and bits 8..0 are the byte offset. Opcode 81h gives `cmd_kind`=1 with the full 10-bit page, `cmd_offset`=0 and `cmd_buf`=0.
- R3: Opcode 50h gives `cmd_kind`=2. `cmd_page` takes frame bits 18..12 in its upper 7 bits and has its low 3 bits forced to 0. `cmd_offset` and `cmd_buf` are 0.
- R4: Opcodes 82h and 85h give `cmd_kind`=3 with `cmd_buf` 0 and 1 respectively. `cmd_page` is frame bits 18..9 and `cmd_offset` is frame bits 8..0.
- R5: Opcodes 53h/55h give `cmd_kind`=4, 60h/61h give `cmd_kind`=5 and 58h/59h give `cmd_kind`=6. The first opcode of each pair sets `cmd_buf`=0 and the second sets 1. `cmd_page` is frame bits 18..9 and `cmd_offset` is 0.
- R6: A command strobe is produced only after `spi_cs_n` rises. It is high on the third rising `clk` edge after that rise, and a frame produces at most one strobe.
- R7: If `spi_cs_n` rises after fewer than 32 bits of an array command, the frame produces no strobe.
- R8: Bits received after the 32nd in a frame do not change the decoded command.
- R9: Each read opcode sets `read_mode`=1 while chip select stays low. The read kind is coded as 68h/E8h = 1, 52h/D2h = 2, 54h/D4h = 3, 56h/D6h = 4 and 57h/D7h = 5, and `read_spi_mode` equals opcode bit 7. A read frame produces no strobe, and all three outputs return to 0 after chip select rises.
- R10: An opcode outside the R2 to R5 and R9 tables produces no strobe and sets `illegal_op`. The flag stays set after chip select rises and clears when the next frame starts.
- R11: The five reserved bits (frame bits 23..19) have no effect on any output.
- R12: `cmd_valid` is high for exactly one `clk` cycle for each accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the device |
| cmd_valid | output | 1 | One-cycle strobe for a decoded array command |
| cmd_kind | output | 3 | Command kind code (R2 to R5) |
| cmd_buf | output | 1 | Buffer select: 0 first buffer, 1 second buffer |
| cmd_page | output | 10 | Target page (block-aligned for block erase) |
| cmd_offset | output | 9 | Starting byte in the buffer, 0 when unused |
| read_mode | output | 1 | A read opcode is active in the open frame |
| read_kind | output | 3 | Read kind code (R9) |
| read_spi_mode | output | 1 | Clocking variant of the active read opcode |
| illegal_op | output | 1 | Sticky unknown-opcode flag |

## Verification
Every serial pin passes through two synchroniser flops and one edge-detect register before any decision is made. As a result, `cmd_valid` is high on the third `clk` edge after chip select rises. The bench samples it on exactly the falling edge after that third rising edge. The read and illegal-opcode flags settle on the fourth edge after the eighth serial clock rise, and the bench reads them a few cycles after the last bit while chip select is still low. Field values and strobe counts are captured by a falling-edge monitor and compared only after the frame has gone quiet for six cycles. This means no check depends on process order at a clock edge.

// File: rtl/sfd_pkg.sv
// Shared widths and types for the serial flash frame decoder.
// Assumes a fixed 8-bit opcode followed by a 24-bit address field.
package sfd_pkg;
    localparam int OP_W    = 8;
    localparam int RSV_W   = 5;
    localparam int PAGE_W  = 10;
    localparam int OFS_W   = 9;
    localparam int ADDR_W  = RSV_W + PAGE_W + OFS_W;
    localparam int FRAME_W = OP_W + ADDR_W;
    localparam int KEEP_W  = PAGE_W + OFS_W;   // address bits that matter
    localparam int BLK_LOG = 3;                // pages per erase block = 2**BLK_LOG

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_PG_ERS  = 3'd1,
        K_BLK_ERS = 3'd2,
        K_PROG    = 3'd3,
        K_XFER    = 3'd4,
        K_CMP     = 3'd5,
        K_REWR    = 3'd6
    } cmd_kind_e;

    typedef enum logic [2:0] {
        RD_NONE  = 3'd0,
        RD_ARRAY = 3'd1,
        RD_PAGE  = 3'd2,
        RD_BUF1  = 3'd3,
        RD_BUF2  = 3'd4,
        RD_STAT  = 3'd5
    } rd_kind_e;

    typedef struct packed {
        logic      legal;
        logic      is_array;
        logic      is_read;
        cmd_kind_e kind;
        logic      buf_sel;
        logic      use_ofs;
        logic      blk;
        rd_kind_e  rkind;
    } op_info_t;
endpackage

// File: rtl/sfd_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes each bit is independent (no bus coherency needed).
module sfd_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sfd_shifter.sv
// Collects the opcode byte and the meaningful address bits of a frame.
// Reserved bits fall off the top of the address register naturally;
// bits after the last frame bit are ignored by a saturating counter.
module sfd_shifter
    import sfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              cs_active,
    input  logic              sck_rise,
    input  logic              sdi,
    output logic [OP_W-1:0]   opcode,
    output logic [KEEP_W-1:0] addr,
    output logic              op_ready,
    output logic              frame_full
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    logic [CNT_W-1:0] cnt;

    // Bit counter and shift registers, cleared at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            opcode <= '0;
            addr   <= '0;
        end else if (frame_start) begin
            cnt    <= '0;
            opcode <= '0;
            addr   <= '0;
        end else if (cs_active && sck_rise && (cnt < CNT_W'(FRAME_W))) begin
            cnt <= cnt + 1'b1;
            if (cnt < CNT_W'(OP_W)) opcode <= {opcode[OP_W-2:0], sdi};
            else                    addr   <= {addr[KEEP_W-2:0], sdi};
        end
    end

    assign op_ready   = (cnt >= CNT_W'(OP_W));
    assign frame_full = (cnt == CNT_W'(FRAME_W));
endmodule

// File: rtl/sfd_opdecode.sv
// Pure lookup from opcode to command attributes.
// Assumes nothing about timing; the caller qualifies the result.
module sfd_opdecode
    import sfd_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_info_t        info
);
    // Classify the opcode into array command, read, or unknown.
    always_comb begin
        info          = '0;
        info.kind     = K_NONE;
        info.rkind    = RD_NONE;
        info.legal    = 1'b1;
        info.is_array = 1'b1;
        unique case (opcode)
            8'h81: info.kind = K_PG_ERS;
            8'h50: begin info.kind = K_BLK_ERS; info.blk = 1'b1; end
            8'h82: begin info.kind = K_PROG; info.use_ofs = 1'b1; end
            8'h85: begin info.kind = K_PROG; info.use_ofs = 1'b1; info.buf_sel = 1'b1; end
            8'h53: info.kind = K_XFER;
            8'h55: begin info.kind = K_XFER; info.buf_sel = 1'b1; end
            8'h60: info.kind = K_CMP;
            8'h61: begin info.kind = K_CMP; info.buf_sel = 1'b1; end
            8'h58: info.kind = K_REWR;
            8'h59: begin info.kind = K_REWR; info.buf_sel = 1'b1; end
            8'h68, 8'hE8: begin info.is_array = 1'b0; info.is_read = 1'b1; info.rkind = RD_ARRAY; end
            8'h52, 8'hD2: begin info.is_array = 1'b0; info.is_read = 1'b1; info.rkind = RD_PAGE; end
            8'h54, 8'hD4: begin info.is_array = 1'b0; info.is_read = 1'b1; info.rkind = RD_BUF1; end
            8'h56, 8'hD6: begin info.is_array = 1'b0; info.is_read = 1'b1; info.rkind = RD_BUF2; end
            8'h57, 8'hD7: begin info.is_array = 1'b0; info.is_read = 1'b1; info.rkind = RD_STAT; end
            default: begin info.is_array = 1'b0; info.legal = 1'b0; end
        endcase
    end
endmodule

// File: rtl/sflash_frame_decoder.sv
// Serial flash command frame decoder, top level.
// Oversamples the serial pins in the system clock domain, so clk must run
// well above twice the serial clock. Commits array commands on the rising
// edge of chip select; flags reads and unknown opcodes during the frame.
module sflash_frame_decoder
    import sfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              cmd_valid,
    output logic [2:0]        cmd_kind,
    output logic              cmd_buf,
    output logic [PAGE_W-1:0] cmd_page,
    output logic [OFS_W-1:0]  cmd_offset,
    output logic              read_mode,
    output logic [2:0]        read_kind,
    output logic              read_spi_mode,
    output logic              illegal_op
);
    logic              s_sck, s_cs_n, s_mosi;
    logic              sck_q, cs_q;
    logic              sck_rise, cs_rise, cs_fall;
    logic [OP_W-1:0]   opcode;
    logic [KEEP_W-1:0] addr;
    logic              op_ready, frame_full;
    op_info_t          info;
    logic              commit, read_now;
    logic [PAGE_W-1:0] page_sel;

    sfd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck, spi_cs_n, spi_mosi}),
        .q     ({s_sck, s_cs_n, s_mosi})
    );

    // Previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= s_sck;
            cs_q  <= s_cs_n;
        end
    end

    assign sck_rise = s_sck & ~sck_q;
    assign cs_rise  = s_cs_n & ~cs_q;
    assign cs_fall  = ~s_cs_n & cs_q;

    sfd_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (cs_fall),
        .cs_active   (~s_cs_n),
        .sck_rise    (sck_rise),
        .sdi         (s_mosi),
        .opcode      (opcode),
        .addr        (addr),
        .op_ready    (op_ready),
        .frame_full  (frame_full)
    );

    sfd_opdecode u_dec (
        .opcode (opcode),
        .info   (info)
    );

    assign commit   = cs_rise & frame_full & info.is_array;
    assign read_now = ~s_cs_n & op_ready & info.is_read;
    assign page_sel = info.blk
                    ? {addr[KEEP_W-1 -: PAGE_W-BLK_LOG], {BLK_LOG{1'b0}}}
                    : addr[KEEP_W-1 -: PAGE_W];

    // Command strobe and its fields, loaded only when a frame commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid  <= 1'b0;
            cmd_kind   <= 3'd0;
            cmd_buf    <= 1'b0;
            cmd_page   <= '0;
            cmd_offset <= '0;
        end else begin
            cmd_valid <= commit;
            if (commit) begin
                cmd_kind   <= info.kind;
                cmd_buf    <= info.buf_sel;
                cmd_page   <= page_sel;
                cmd_offset <= info.use_ofs ? addr[OFS_W-1:0] : '0;
            end
        end
    end

    // Read-mode flags follow the open frame's opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_mode     <= 1'b0;
            read_kind     <= 3'd0;
            read_spi_mode <= 1'b0;
        end else begin
            read_mode     <= read_now;
            read_kind     <= read_now ? info.rkind : RD_NONE;
            read_spi_mode <= read_now & opcode[OP_W-1];
        end
    end

    // Sticky unknown-opcode flag, cleared when a new frame opens.
    always_ff @(posedge clk) begin
        if (!rst_n)                        illegal_op <= 1'b0;
        else if (cs_fall)                  illegal_op <= 1'b0;
        else if (op_ready && !info.legal)  illegal_op <= 1'b1;
    end
endmodule

// File: rtl/sfd_checker.sv
// Temporal properties of the frame decoder outputs, bound to the top.
module sfd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_kind,
    input logic       cmd_buf,
    input logic [9:0] cmd_page,
    input logic [8:0] cmd_offset,
    input logic       read_mode,
    input logic [2:0] read_kind,
    input logic       illegal_op
);
    p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_after_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> spi_cs_n);

    p_kind_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_kind >= 3'd1 && cmd_kind <= 3'd6));

    p_block_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 3'd2) |-> (cmd_page[2:0] == 3'd0 && !cmd_buf));

    p_offset_prog_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind != 3'd3) |-> (cmd_offset == 9'd0));

    p_erase_buf_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 3'd1) |-> !cmd_buf);

    p_read_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        read_mode |-> (!cmd_valid && read_kind != 3'd0));

    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (!cmd_valid && !read_mode));
endmodule

bind sflash_frame_decoder sfd_checker u_chk (.*);

// File: tb/sflash_frame_decoder_test.sv
module sflash_frame_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       cmd_valid, cmd_buf, read_mode, read_spi_mode, illegal_op;
    logic [2:0] cmd_kind, read_kind;
    logic [9:0] cmd_page;
    logic [8:0] cmd_offset;

    int nchk = 0, nfail = 0, nstrobe = 0;
    logic [2:0] c_kind;
    logic       c_buf;
    logic [9:0] c_page;
    logic [8:0] c_ofs;

    always #4 clk = ~clk;

    sflash_frame_decoder uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_buf(cmd_buf), .cmd_page(cmd_page), .cmd_offset(cmd_offset),
        .read_mode(read_mode), .read_kind(read_kind),
        .read_spi_mode(read_spi_mode), .illegal_op(illegal_op)
    );

    // Capture every strobe cycle away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            nstrobe = nstrobe + 1;
            c_kind  = cmd_kind;
            c_buf   = cmd_buf;
            c_page  = cmd_page;
            c_ofs   = cmd_offset;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected decode of a frame, written from the requirements.
    function automatic void model(input logic [7:0] op, input logic [23:0] a,
                                  output logic arr, output logic [2:0] k,
                                  output logic bsel, output logic [9:0] pg,
                                  output logic [8:0] of, output logic legal,
                                  output logic [2:0] rk);
        arr = 1'b1; k = 3'd0; bsel = 1'b0; pg = a[18:9]; of = 9'd0;
        legal = 1'b1; rk = 3'd0;
        case (op)
            8'h81: k = 3'd1;
            8'h50: begin k = 3'd2; pg = {a[18:12], 3'b000}; end
            8'h82, 8'h85: begin k = 3'd3; bsel = (op == 8'h85); of = a[8:0]; end
            8'h53, 8'h55: begin k = 3'd4; bsel = (op == 8'h55); end
            8'h60, 8'h61: begin k = 3'd5; bsel = (op == 8'h61); end
            8'h58, 8'h59: begin k = 3'd6; bsel = (op == 8'h59); end
            8'h68, 8'hE8: begin arr = 1'b0; rk = 3'd1; end
            8'h52, 8'hD2: begin arr = 1'b0; rk = 3'd2; end
            8'h54, 8'hD4: begin arr = 1'b0; rk = 3'd3; end
            8'h56, 8'hD6: begin arr = 1'b0; rk = 3'd4; end
            8'h57, 8'hD7: begin arr = 1'b0; rk = 3'd5; end
            default: begin arr = 1'b0; legal = 1'b0; end
        endcase
    endfunction

    task automatic run_frame(input string tag, input logic [7:0] op,
                             input logic [23:0] a, input logic [7:0] extra,
                             input int nbits);
        logic [39:0] w;
        logic arr, bsel, legal, opr, exp_strobe;
        logic [2:0] k, rk;
        logic [9:0] pg;
        logic [8:0] of;
        int base;
        w = {op, a, extra};
        model(op, a, arr, k, bsel, pg, of, legal, rk);
        opr = (nbits >= 8);
        exp_strobe = arr && (nbits >= 32);

        spi_cs_n = 1'b0;
        tick(5);
        check("R10 illegal_op clears at frame start", int'(illegal_op), 0);
        base = nstrobe;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = w[39-i];
            tick(3);
            spi_sck = 1'b1;
            tick(3);
            spi_sck = 1'b0;
        end
        tick(5);
        check({tag, " R9 read_mode in frame"}, int'(read_mode), int'(opr && rk != 0));
        check({tag, " R9 read_kind in frame"}, int'(read_kind), opr ? int'(rk) : 0);
        check({tag, " R9 read_spi_mode"}, int'(read_spi_mode), int'(opr && rk != 0 && op[7]));
        check({tag, " R10 illegal_op in frame"}, int'(illegal_op), int'(opr && !legal));

        spi_cs_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({tag, " R6 strobe on third edge"}, int'(cmd_valid), int'(exp_strobe));
        tick(6);
        check({tag, " R7 R12 strobe cycles"}, nstrobe - base, exp_strobe ? 1 : 0);
        if (exp_strobe) begin
            check({tag, " cmd_kind"}, int'(c_kind), int'(k));
            check({tag, " cmd_buf"}, int'(c_buf), int'(bsel));
            check({tag, " cmd_page"}, int'(c_page), int'(pg));
            check({tag, " cmd_offset"}, int'(c_ofs), int'(of));
        end
        check({tag, " R9 read_mode after cs rise"}, int'(read_mode), 0);
        check({tag, " R10 illegal_op sticky"}, int'(illegal_op), int'(opr && !legal));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [7:0] ops [20];
        logic [7:0] op;
        int nb, r;
        ops = '{8'h81, 8'h50, 8'h82, 8'h85, 8'h53, 8'h55, 8'h60, 8'h61, 8'h58, 8'h59,
                8'h68, 8'hE8, 8'h52, 8'hD2, 8'h54, 8'hD4, 8'h56, 8'hD6, 8'h57, 8'hD7};
        void'($urandom(32'h5EED_0042));

        tick(4);
        check("R1 reset cmd_valid", int'(cmd_valid), 0);
        check("R1 reset fields", int'({cmd_kind, cmd_buf, cmd_page, cmd_offset}), 0);
        check("R1 reset flags", int'({read_mode, read_kind, read_spi_mode, illegal_op}), 0);
        rst_n = 1'b1;
        tick(4);
        check("R1 idle after reset", int'({cmd_valid, read_mode, illegal_op}), 0);

        run_frame("R2 page erase", 8'h81, {5'h00, 10'h2A5, 9'h1FF}, 8'h00, 32);
        run_frame("R11 reserved ones", 8'h81, {5'h1F, 10'h2A5, 9'h1FF}, 8'h00, 32);
        run_frame("R3 block erase", 8'h50, {5'h0A, 10'h3FF, 9'h123}, 8'h00, 32);
        run_frame("R4 program buf2", 8'h85, {5'h00, 10'h155, 9'h1FF}, 8'h00, 32);
        run_frame("R4 program buf1", 8'h82, {5'h1F, 10'h001, 9'h000}, 8'h00, 32);
        run_frame("R5 transfer buf2", 8'h55, {5'h00, 10'h3FE, 9'h0AA}, 8'h00, 32);
        run_frame("R5 compare buf1", 8'h60, {5'h00, 10'h200, 9'h101}, 8'h00, 32);
        run_frame("R5 rewrite buf2", 8'h59, {5'h00, 10'h0F0, 9'h1F0}, 8'h00, 32);
        run_frame("R7 short frame", 8'h81, {5'h00, 10'h111, 9'h011}, 8'h00, 31);
        run_frame("R7 opcode only", 8'h82, {5'h00, 10'h111, 9'h011}, 8'h00, 8);
        run_frame("R8 long frame", 8'h82, {5'h00, 10'h0C3, 9'h0A5}, 8'hA5, 40);
        run_frame("R9 status read", 8'hD7, 24'h000000, 8'h00, 32);
        run_frame("R9 array read", 8'h68, 24'hFFFFFF, 8'h00, 16);
        run_frame("R10 illegal", 8'h00, 24'h123456, 8'h00, 32);
        run_frame("R10 after illegal", 8'h53, {5'h00, 10'h0AB, 9'h000}, 8'h00, 32);

        for (int n = 0; n < 50; n++) begin
            r  = int'($urandom % 8);
            nb = (r == 0) ? 1 + int'($urandom % 31) : (r == 1) ? 33 + int'($urandom % 8) : 32;
            op = ($urandom % 5 == 0) ? 8'($urandom) : ops[$urandom % 20];
            run_frame("R11 random", op, 24'($urandom), 8'($urandom), nb);
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule